// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns single requests from an internal master into complete read or write cycles on an external parallel memory bus. A request carries direction, address and write data. It is held until the block takes it. When the cycle finishes, the block gives a one-cycle completion pulse, and for reads it also returns the captured data. The block drives chip select, an address-latch strobe, active-low read and write strobes and a data bus. The bus can share address and data on the same lines, or it can put the address on its own lines.

All timing is counted in external-clock periods. The `tick` input marks each period with a single-cycle pulse, and every phase change happens on a tick. A cycle goes through these phases: one setup period, an address-latch pulse, one latch-hold period, the access phase with a strobe, and an optional hold phase. Idle gaps can follow. One gap comes after every write. Another comes between a read and a read that is already waiting. In continuous mode, a request that is already waiting when the previous cycle ends goes straight to the access phase. The integrator sets the configuration inputs while the bus is idle.

Top module: `ext_bus_seq`

## Requirements
- R1: Each cycle begins with one setup period. An address-latch pulse of `cfg_t_latch`+1 periods follows, then one latch-hold period. Chip select is active through all three. `bus_ale` never overlaps a strobe and changes only after a tick.
- R2: The read or write strobe is low for `cfg_t_access`+1 periods. Read data is captured at the end of this phase and presented on `rsp_rdata` together with `rsp_done`.
- R3: A hold phase of `cfg_t_hold`+1 periods follows the strobe, with chip select still active. It is left out on reads when `cfg_hold_off_rd`=1 and on writes when `cfg_hold_off_wr`=1.
- R4: After every write, chip select stays inactive for `cfg_gap_wr` periods before the next cycle starts. A value of 0 means no gap.
- R5: When a read ends and a read request is already waiting, chip select stays inactive for `cfg_gap_rd` periods. No such gap is inserted when the waiting request is a write.
- R6: With `cfg_burst`=1, a request that is waiting when the previous cycle ends, with no gap due, skips setup, latch and latch hold. Its chip-select time is then access plus hold only.
- R7: The active level of chip select equals `cfg_cs_high` (0 = active low, 1 = active high). Chip select is active whenever a strobe is low.
- R8: With `cfg_wide`=0 (8-bit bus), write data on `bus_ad_out[15:8]` is 0 while the write strobe is low, and `rsp_rdata[15:8]` returns 0. With `cfg_wide`=1, all 16 bits are used.
- R9: With `cfg_split`=0, the address low bits are driven on `bus_ad_out` during setup, latch and latch hold, and `bus_addr` stays 0. With `cfg_split`=1, the address appears on `bus_addr` while chip select is active.
- R10: While `cfg_enable`=0, no request is taken (`req_ready`=0). Chip select, `bus_ale`, `bus_rd_n` and `bus_wr_n` are held at their inactive levels.
- R11: Every accepted request produces exactly one `rsp_done` pulse, one cycle long, in acceptance order. The read and write strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse marking each external clock period |
| cfg_enable | input | 1 | Block enable |
| cfg_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| cfg_cs_high | input | 1 | Chip select active level |
| cfg_split | input | 1 | 1 = separate address bus, 0 = shared address/data |
| cfg_burst | input | 1 | Continuous access shortcut |
| cfg_t_latch | input | 3 | Latch pulse length minus one |
| cfg_t_access | input | 5 | Access phase length minus one |
| cfg_t_hold | input | 3 | Hold phase length minus one |
| cfg_hold_off_rd | input | 1 | Skip hold on reads |
| cfg_hold_off_wr | input | 1 | Skip hold on writes |
| cfg_gap_wr | input | 4 | Idle periods after a write |
| cfg_gap_rd | input | 4 | Idle periods between reads |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Request address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request taken at this clock edge when valid |
| rsp_done | output | 1 | Cycle completed pulse |
| rsp_rdata | output | 16 | Read data |
| bus_cs | output | 1 | Chip select |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ad_out | output | 16 | Shared address/data or data output |
| bus_ad_oe | output | 1 | Output enable for bus_ad_out |
| bus_addr | output | 20 | Separate address bus |
| bus_din | input | 16 | Data from the external device |

## Verification
Some properties are checked on every cycle. The two strobes never overlap, and the latch pulse never overlaps a strobe. The latch pulse moves only after a tick. Chip select is active whenever a strobe is low. The completion pulse lasts a single cycle. A disabled block keeps its strobes quiet and takes no request. Other behaviour can only be shown by the bench scenarios. A bus-side memory model and a queue of expected results measure these across chained and isolated requests: phase lengths in ticks, idle gaps that depend on direction, the continuous shortcut, byte-lane masking, and correct address latching in both bus modes.

// File: rtl/ebs_pkg.sv
// Shared types for the external bus cycle sequencer.
// Assumes: all field widths below match the top-level configuration ports.
package ebs_pkg;

    localparam int LATCH_W = 3;
    localparam int ACC_W   = 5;
    localparam int HOLD_W  = 3;
    localparam int GAP_W   = 4;
    localparam int CNT_W   = 5;   // wide enough for the longest phase field

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ALE,
        PH_LHOLD,
        PH_ACCESS,
        PH_HOLD,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic [LATCH_W-1:0] t_latch;
        logic [ACC_W-1:0]   t_access;
        logic [HOLD_W-1:0]  t_hold;
        logic [GAP_W-1:0]   gap_wr;
        logic [GAP_W-1:0]   gap_rd;
        logic               hold_off_rd;
        logic               hold_off_wr;
        logic               burst;
    } timing_t;

endpackage

// File: rtl/ebs_phase_timer.sv
// Down-counter that measures one bus phase in external-clock ticks.
// A load sets the count to (length-1); expired pulses on the tick that
// ends the phase. Assumes tick is a single-cycle pulse.
module ebs_phase_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Load on phase entry, otherwise count down once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The phase ends on the tick seen while the count is zero.
    assign expired = tick && (cnt_q == '0);

endmodule

// File: rtl/ebs_sequencer.sv
// Phase state machine of the bus sequencer. It accepts a request at a tick
// and walks setup, latch, latch hold, access and hold. It then inserts the
// idle gap that the direction calls for. It captures read data and issues
// the completion pulse.
// Assumes: configuration is static while a cycle is in flight.
module ebs_sequencer
    import ebs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          enable,
    input  logic          wide,
    input  timing_t       tm,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] din,
    output logic          req_ready,
    output phase_e        phase,
    output logic          cyc_write,
    output logic [AW-1:0] cyc_addr,
    output logic [DW-1:0] cyc_wdata,
    output logic          done,
    output logic [DW-1:0] rdata
);

    localparam int HALF = DW / 2;

    phase_e             phase_q, phase_d;
    logic               ld;
    logic [CNT_W-1:0]   ld_val;
    logic               expired;
    logic               skip_hold;
    logic               final_end;
    logic [GAP_W-1:0]   gap_len;
    logic               gap_needed;
    logic               accept;
    phase_e             end_phase;
    logic [CNT_W-1:0]   end_val;
    logic               write_q;
    logic [AW-1:0]      addr_q;
    logic [DW-1:0]      wdata_q;
    logic               done_q;
    logic [DW-1:0]      rdata_q;

    ebs_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    // The hold phase is dropped for the direction whose hold-off bit is set.
    assign skip_hold = write_q ? tm.hold_off_wr : tm.hold_off_rd;

    // The tick that leaves the last active phase of the cycle.
    assign final_end = expired &&
                       ((phase_q == PH_HOLD) || ((phase_q == PH_ACCESS) && skip_hold));

    // Idle gap length due after the current cycle.
    always_comb begin
        if (write_q) begin
            gap_len = tm.gap_wr;
        end else if (req_valid && !req_write) begin
            gap_len = tm.gap_rd;
        end else begin
            gap_len = '0;
        end
    end

    assign gap_needed = (gap_len != '0);

    // Request slots: idle tick, last gap tick, or a cycle end with no gap due.
    assign req_ready = enable && tick &&
                       ((phase_q == PH_IDLE) ||
                        ((phase_q == PH_GAP) && expired) ||
                        (final_end && !gap_needed));
    assign accept = req_ready && req_valid;

    // Where a finished cycle goes next.
    always_comb begin
        if (gap_needed) begin
            end_phase = PH_GAP;
            end_val   = CNT_W'(gap_len - 1'b1);
        end else if (accept && tm.burst) begin
            end_phase = PH_ACCESS;
            end_val   = CNT_W'(tm.t_access);
        end else if (accept) begin
            end_phase = PH_SETUP;
            end_val   = '0;
        end else begin
            end_phase = PH_IDLE;
            end_val   = '0;
        end
    end

    // Next phase and the timer load that goes with it.
    always_comb begin
        phase_d = phase_q;
        ld      = 1'b0;
        ld_val  = '0;
        if (!enable) begin
            phase_d = PH_IDLE;
            ld      = 1'b1;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_d = PH_SETUP;
                        ld      = 1'b1;
                    end
                end
                PH_SETUP: begin
                    if (expired) begin
                        phase_d = PH_ALE;
                        ld      = 1'b1;
                        ld_val  = CNT_W'(tm.t_latch);
                    end
                end
                PH_ALE: begin
                    if (expired) begin
                        phase_d = PH_LHOLD;
                        ld      = 1'b1;
                    end
                end
                PH_LHOLD: begin
                    if (expired) begin
                        phase_d = PH_ACCESS;
                        ld      = 1'b1;
                        ld_val  = CNT_W'(tm.t_access);
                    end
                end
                PH_ACCESS: begin
                    if (expired && !skip_hold) begin
                        phase_d = PH_HOLD;
                        ld      = 1'b1;
                        ld_val  = CNT_W'(tm.t_hold);
                    end else if (expired) begin
                        phase_d = end_phase;
                        ld      = 1'b1;
                        ld_val  = end_val;
                    end
                end
                PH_HOLD: begin
                    if (expired) begin
                        phase_d = end_phase;
                        ld      = 1'b1;
                        ld_val  = end_val;
                    end
                end
                PH_GAP: begin
                    if (expired) begin
                        phase_d = accept ? PH_SETUP : PH_IDLE;
                        ld      = 1'b1;
                    end
                end
                default: begin
                    phase_d = PH_IDLE;
                    ld      = 1'b1;
                end
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Capture the request fields when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            write_q <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample read data at the end of access, masked to the active lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if ((phase_q == PH_ACCESS) && expired && !write_q) begin
            rdata_q <= wide ? din : {{HALF{1'b0}}, din[HALF-1:0]};
        end
    end

    // One-cycle completion pulse after the final phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= enable && final_end;
        end
    end

    assign phase     = phase_q;
    assign cyc_write = write_q;
    assign cyc_addr  = addr_q;
    assign cyc_wdata = wdata_q;
    assign done      = done_q;
    assign rdata     = rdata_q;

endmodule

// File: rtl/ebs_pin_driver.sv
// Maps the current phase onto the external pins: chip select with
// selectable level, latch strobe, read/write strobes, and the shared or
// separate address/data lines.
// Assumes: AW >= DW so the shared bus can carry the low address bits.
module ebs_pin_driver
    import ebs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          enable,
    input  logic          cs_high,
    input  logic          split,
    input  logic          wide,
    input  phase_e        phase,
    input  logic          cyc_write,
    input  logic [AW-1:0] cyc_addr,
    input  logic [DW-1:0] cyc_wdata,
    output logic          bus_cs,
    output logic          bus_ale,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic [DW-1:0] bus_ad_out,
    output logic          bus_ad_oe,
    output logic [AW-1:0] bus_addr
);

    localparam int HALF = DW / 2;

    logic          active;
    logic          addr_phase;
    logic          data_phase;
    logic [DW-1:0] wdata_lane;

    // Phase decode shared by all pins.
    always_comb begin
        active     = enable && (phase inside {PH_SETUP, PH_ALE, PH_LHOLD, PH_ACCESS, PH_HOLD});
        addr_phase = enable && (phase inside {PH_SETUP, PH_ALE, PH_LHOLD});
        data_phase = enable && cyc_write && (phase inside {PH_ACCESS, PH_HOLD});
    end

    // Upper byte lane is forced to zero on an 8-bit bus.
    assign wdata_lane = wide ? cyc_wdata : {{HALF{1'b0}}, cyc_wdata[HALF-1:0]};

    // Control strobes.
    always_comb begin
        bus_cs   = cs_high ? active : !active;
        bus_ale  = enable && (phase == PH_ALE);
        bus_rd_n = !(enable && (phase == PH_ACCESS) && !cyc_write);
        bus_wr_n = !(enable && (phase == PH_ACCESS) && cyc_write);
    end

    // Address and data lines for the selected bus arrangement.
    always_comb begin
        if (split) begin
            bus_addr   = active ? cyc_addr : '0;
            bus_ad_oe  = data_phase;
            bus_ad_out = data_phase ? wdata_lane : '0;
        end else begin
            bus_addr   = '0;
            bus_ad_oe  = addr_phase || data_phase;
            if (addr_phase) begin
                bus_ad_out = cyc_addr[DW-1:0];
            end else if (data_phase) begin
                bus_ad_out = wdata_lane;
            end else begin
                bus_ad_out = '0;
            end
        end
    end

endmodule

// File: rtl/ext_bus_seq.sv
// Top of the external memory bus cycle sequencer. It gathers the timing
// fields into one structure and connects the phase machine to the pin
// driver. Assumes: tick is a one-cycle pulse per external clock period,
// and configuration changes only while no cycle is in flight.
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cfg_enable,
    input  logic          cfg_wide,
    input  logic          cfg_cs_high,
    input  logic          cfg_split,
    input  logic          cfg_burst,
    input  logic [2:0]    cfg_t_latch,
    input  logic [4:0]    cfg_t_access,
    input  logic [2:0]    cfg_t_hold,
    input  logic          cfg_hold_off_rd,
    input  logic          cfg_hold_off_wr,
    input  logic [3:0]    cfg_gap_wr,
    input  logic [3:0]    cfg_gap_rd,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_cs,
    output logic          bus_ale,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic [DW-1:0] bus_ad_out,
    output logic          bus_ad_oe,
    output logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_din
);

    timing_t       tm;
    phase_e        phase;
    logic          cyc_write;
    logic [AW-1:0] cyc_addr;
    logic [DW-1:0] cyc_wdata;

    // Bundle the timing configuration.
    always_comb begin
        tm.t_latch     = cfg_t_latch;
        tm.t_access    = cfg_t_access;
        tm.t_hold      = cfg_t_hold;
        tm.gap_wr      = cfg_gap_wr;
        tm.gap_rd      = cfg_gap_rd;
        tm.hold_off_rd = cfg_hold_off_rd;
        tm.hold_off_wr = cfg_hold_off_wr;
        tm.burst       = cfg_burst;
    end

    ebs_sequencer #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .enable    (cfg_enable),
        .wide      (cfg_wide),
        .tm        (tm),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .din       (bus_din),
        .req_ready (req_ready),
        .phase     (phase),
        .cyc_write (cyc_write),
        .cyc_addr  (cyc_addr),
        .cyc_wdata (cyc_wdata),
        .done      (rsp_done),
        .rdata     (rsp_rdata)
    );

    ebs_pin_driver #(.AW(AW), .DW(DW)) u_pins (
        .enable     (cfg_enable),
        .cs_high    (cfg_cs_high),
        .split      (cfg_split),
        .wide       (cfg_wide),
        .phase      (phase),
        .cyc_write  (cyc_write),
        .cyc_addr   (cyc_addr),
        .cyc_wdata  (cyc_wdata),
        .bus_cs     (bus_cs),
        .bus_ale    (bus_ale),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .bus_ad_out (bus_ad_out),
        .bus_ad_oe  (bus_ad_oe),
        .bus_addr   (bus_addr)
    );

endmodule

// File: rtl/ext_bus_seq_chk.sv
// Protocol checker for ext_bus_seq, attached through bind.
// Assumes: configuration stays static while a cycle is in flight.
module ext_bus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic cfg_enable,
    input logic cfg_cs_high,
    input logic req_ready,
    input logic rsp_done,
    input logic bus_cs,
    input logic bus_ale,
    input logic bus_rd_n,
    input logic bus_wr_n
);

    // R1: the latch pulse and a data strobe are never active together.
    p_ale_no_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_rd_n && bus_wr_n));

    // R1: the latch pulse moves only after a tick.
    p_ale_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && cfg_enable) |=> (!cfg_enable || $stable(bus_ale)));

    // R7: chip select is at its active level whenever a strobe is low.
    p_strobe_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> (bus_cs == cfg_cs_high));

    // R10: a disabled block takes nothing and keeps its strobes quiet.
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> (!req_ready && !bus_ale && bus_rd_n && bus_wr_n));

    // R11: completion is a single-cycle pulse.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R11: read and write strobes are mutually exclusive.
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> bus_wr_n);

endmodule

bind ext_bus_seq ext_bus_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .cfg_enable  (cfg_enable),
    .cfg_cs_high (cfg_cs_high),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .bus_cs      (bus_cs),
    .bus_ale     (bus_ale),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n)
);

// File: tb/tb_ext_bus_seq.sv
// Scoreboard bench: the driver task queues the expected timing and data of
// each request, a monitor measures the bus and pops on each completion.
module tb_ext_bus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cfg_enable = 1'b1;
    logic        cfg_wide = 1'b1;
    logic        cfg_cs_high = 1'b0;
    logic        cfg_split = 1'b0;
    logic        cfg_burst = 1'b0;
    logic [2:0]  cfg_t_latch = 3'd2;
    logic [4:0]  cfg_t_access = 5'd3;
    logic [2:0]  cfg_t_hold = 3'd1;
    logic        cfg_hold_off_rd = 1'b0;
    logic        cfg_hold_off_wr = 1'b0;
    logic [3:0]  cfg_gap_wr = 4'd2;
    logic [3:0]  cfg_gap_rd = 4'd3;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        bus_cs, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe;
    logic [15:0] bus_ad_out;
    logic [19:0] bus_addr;
    logic [15:0] bus_din;

    always #10 clk = ~clk;   // 50 MHz

    ext_bus_seq dut (.*);

    typedef struct {
        bit        wr;
        int        rdata;
        int        ale;
        int        strobe;
        int        cs;
        int        gap;
    } exp_item_t;

    exp_item_t   exp_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          prev_wr = 1'b0;
    logic [15:0] shadow [256];
    logic [15:0] model  [256];
    logic [7:0]  lat_addr = '0;
    logic [7:0]  rd_idx;

    // External device model: address latch, write capture, read data.
    assign rd_idx  = cfg_split ? bus_addr[7:0] : lat_addr;
    assign bus_din = model[rd_idx];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Tick: one cycle in three.
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div + 1) % 3;
            tick = (div == 0);
        end
    end

    // Device model, evaluated after inputs settle.
    initial begin
        bit         ale_prev = 1'b0;
        bit         pend = 1'b0;
        logic [7:0] pa = '0;
        logic [15:0] pd = '0;
        for (int i = 0; i < 256; i++) begin
            model[i] = '0;
            shadow[i] = '0;
        end
        forever begin
            @(negedge clk);
            #3;
            if (ale_prev && !bus_ale && !cfg_split) lat_addr = bus_ad_out[7:0];
            ale_prev = bus_ale;
            if (!bus_wr_n) begin
                pend = 1'b1;
                pa = cfg_split ? bus_addr[7:0] : lat_addr;
                pd = bus_ad_out;
            end else if (pend) begin
                model[pa] = pd;
                pend = 1'b0;
            end
        end
    end

    // Monitor: count ticks per phase and compare on each completion.
    initial begin
        int c_ale = 0, c_str = 0, c_cs = 0, c_gap = 0;
        int f7 = 0, f8 = 0, f9 = 0;
        exp_item_t it;
        forever begin
            @(negedge clk);
            #3;
            if (rsp_done) begin
                if (exp_q.size() == 0) begin
                    chk("R11 done without request", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    chk("R1 latch ticks", c_ale, it.ale);
                    chk("R2 strobe ticks", c_str, it.strobe);
                    chk("R3 chip select ticks", c_cs, it.cs);
                    if (!it.wr) chk("R2 R8 read data", int'(rsp_rdata), it.rdata);
                    if (it.gap >= 0) chk("R4 R5 R6 idle gap ticks", c_gap, it.gap);
                    chk("R7 cs active under strobe", f7, 0);
                    chk("R8 upper lane zero", f8, 0);
                    chk("R9 address bus quiet", f9, 0);
                end
                c_ale = 0; c_str = 0; c_cs = 0; c_gap = 0;
                f7 = 0; f8 = 0; f9 = 0;
            end
            if (tick) begin
                if (bus_cs == cfg_cs_high) c_cs++;
                else if (req_valid) c_gap++;
                if (bus_ale) c_ale++;
                if (!bus_rd_n || !bus_wr_n) c_str++;
            end
            if ((!bus_rd_n || !bus_wr_n) && (bus_cs != cfg_cs_high)) f7++;
            if (!bus_wr_n && !cfg_wide && (bus_ad_out[15:8] != 8'h00)) f8++;
            if (!cfg_split && (bus_addr != '0)) f9++;
        end
    end

    // Driver: queue the expectation, then hold the request until taken.
    task automatic send(input bit wr, input logic [7:0] a, input logic [15:0] d,
                        input bit chained);
        exp_item_t it;
        int hold;
        int gap;
        hold = (wr ? cfg_hold_off_wr : cfg_hold_off_rd) ? 0 : int'(cfg_t_hold) + 1;
        gap  = prev_wr ? int'(cfg_gap_wr) : (!wr ? int'(cfg_gap_rd) : 0);
        it.wr     = wr;
        it.strobe = int'(cfg_t_access) + 1;
        it.gap    = chained ? gap : -1;
        if (chained && cfg_burst && gap == 0) begin
            it.ale = 0;
            it.cs  = it.strobe + hold;
        end else begin
            it.ale = int'(cfg_t_latch) + 1;
            it.cs  = 1 + it.ale + 1 + it.strobe + hold;
        end
        if (wr) shadow[a] = cfg_wide ? d : {8'h00, d[7:0]};
        it.rdata = cfg_wide ? int'(shadow[a]) : int'(shadow[a][7:0]);
        req_valid = 1'b1; req_write = wr; req_addr = {12'h0, a}; req_wdata = d;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(it);
        prev_wr = wr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (60) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R7, R10, R11 idle levels).
        chk("R7 reset cs inactive", bus_cs, 1);
        chk("R1 reset ale low", bus_ale, 0);
        chk("R11 reset strobes high", {bus_rd_n, bus_wr_n}, 2'b11);
        chk("R11 reset done low", rsp_done, 0);

        // Shared bus, 16-bit: R1 R2 R3 R4 R5 R9.
        send(1'b1, 8'h21, 16'hBEEF, 1'b0);
        send(1'b1, 8'h22, 16'h1234, 1'b1);   // R4 write->write gap
        send(1'b0, 8'h21, 16'h0, 1'b1);      // R4 write->read gap
        send(1'b0, 8'h22, 16'h0, 1'b1);      // R5 read->read gap
        send(1'b1, 8'h23, 16'h5A5A, 1'b1);   // R5 no gap before write
        drain();

        // Hold disabled both ways, shortest phases: R3.
        cfg_hold_off_rd = 1'b1; cfg_hold_off_wr = 1'b1;
        cfg_t_latch = 3'd0; cfg_t_access = 5'd0; cfg_gap_wr = 4'd0; cfg_gap_rd = 4'd0;
        send(1'b1, 8'h30, 16'h0F0F, 1'b0);
        send(1'b0, 8'h30, 16'h0, 1'b1);
        send(1'b0, 8'h23, 16'h0, 1'b1);
        drain();

        // Separate address bus with continuous access: R6 R9.
        cfg_hold_off_rd = 1'b0; cfg_hold_off_wr = 1'b0;
        cfg_t_latch = 3'd1; cfg_t_access = 5'd2; cfg_t_hold = 3'd0;
        cfg_split = 1'b1; cfg_burst = 1'b1;
        send(1'b1, 8'h40, 16'hC001, 1'b0);
        send(1'b1, 8'h41, 16'hC002, 1'b1);
        send(1'b0, 8'h40, 16'h0, 1'b1);
        send(1'b0, 8'h41, 16'h0, 1'b1);
        drain();
        cfg_gap_rd = 4'd2;                   // R5 gap overrides the shortcut
        send(1'b0, 8'h40, 16'h0, 1'b0);
        send(1'b0, 8'h41, 16'h0, 1'b1);
        drain();

        // 8-bit bus on the shared lines: R8.
        cfg_split = 1'b0; cfg_burst = 1'b0; cfg_wide = 1'b0;
        send(1'b1, 8'h50, 16'hA5C3, 1'b0);
        send(1'b0, 8'h21, 16'h0, 1'b0);
        drain();
        cfg_wide = 1'b1;
        send(1'b0, 8'h50, 16'h0, 1'b0);
        drain();

        // Active-high chip select: R7.
        cfg_cs_high = 1'b1;
        @(negedge clk);
        chk("R7 idle cs level high polarity", bus_cs, 0);
        send(1'b1, 8'h60, 16'h7E57, 1'b0);
        send(1'b0, 8'h60, 16'h0, 1'b1);
        drain();

        // Disabled block: R10.
        cfg_enable = 1'b0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h61; req_wdata = 16'h9999;
        begin
            int bad = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                #3;
                if (req_ready || bus_ale || !bus_rd_n || !bus_wr_n || bus_cs != 1'b0) bad++;
            end
            chk("R10 disabled outputs inactive", bad, 0);
        end
        cfg_enable = 1'b1;
        send(1'b1, 8'h61, 16'h9999, 1'b0);
        send(1'b0, 8'h61, 16'h0, 1'b1);
        drain();

        chk("R11 all requests completed", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule